// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts cycles and hardware events for profiling. It holds one free-running 64-bit cycle counter and a small bank of 32-bit event counters. Each event counter carries a programmable event number, and that number picks one line of an incoming vector of single-cycle event pulses. A counter advances only while its own enable bit and the global enable are both set.

Software reaches the unit over a simple single-cycle register bus. Event counters are never addressed directly. A select register names one counter, and two shared windows then read or write that counter's event number and its count. A user-access register decides what an unprivileged requester may touch. It grants general access, cycle-counter reads and event-counter reads through separate bits. A denied request returns zero, raises an error flag and changes no state.

Top module: `perf_counter_unit`

## Requirements
- R1: After synchronous reset, every register and counter reads zero, and `rsp_valid` and `rsp_err` are low.
- R2: The cycle counter advances by exactly one on each clock edge at which control bit 0 and enable bit 31 are both set, and holds otherwise. Address 6 reads its low 32 bits and address 7 reads its high 32 bits.
- R3: Event counter i advances by one on each edge at which control bit 0 is set, enable bit i is set, and `evt_in[type_i]` is high. It holds when any of these is missing.
- R4: A write to the enable-set register (address 1) sets every bit written as 1. A write to the enable-clear register (address 2) clears every bit written as 1. Only bits 0 to NUM_CTR-1 and bit 31 exist. Reads of either address return the current mask.
- R5: Control register, address 0: bit 0 is the global enable. Writing 1 to bit 1 zeroes the cycle counter, and writing 1 to bit 2 zeroes every event counter. Bits 1 and 2 always read 0. A clear that lands in the same cycle as an event pulse leaves the counter at zero.
- R6: The select register (address 3, bits 4:0) picks the counter used by the event-type window (address 4) and the count window (address 5). A write to the count window loads the selected counter.
- R7: While the select value is NUM_CTR or higher, both windows read zero, and writes to them change no counter and no event number.
- R8: An event number of NUM_EVT_IN or above never advances its counter.
- R9: The user-access register (address 8) has bit 0 for general unprivileged access, bit 2 for cycle-counter reads and bit 3 for event-count reads. Bit 1 always reads 0. An unprivileged write to address 8 is always denied. A denied request returns data 0 with `rsp_err` high for that one response, and it changes no state.
- R10: An unprivileged read of the count window is denied while bit 3 is clear, even when bit 0 is set and the counter is enabled. An unprivileged cycle-counter read succeeds whenever bit 2 is set.
- R11: Every request accepted with `req_valid` gets exactly one response on the following cycle. A write response carries data 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | NUM_EVT_IN | Single-cycle event pulses, indexed by event number |
| req_valid | input | 1 | Register request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged requester |
| req_addr | input | 4 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_data | output | 32 | Read data (zero for writes and denials) |
| rsp_err | output | 1 | Request was denied by the access rules |

## Verification
The bench builds the block with its default parameters: six event counters, ten event inputs and an 8-bit event-number field. The narrow input vector behind a wide number field lets the bench program event numbers such as 200, which no input backs (R8). The 5-bit select field reaches values from 6 to 31, which exercises the out-of-range window behaviour (R7). With six counters, the enable-set write of all ones shows the unimplemented middle bits reading back as zero next to bit 31.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int PMC_BUS_W  = 32;
    localparam int PMC_ADDR_W = 4;
    localparam int PMC_SEL_W  = 5;
    localparam int PMC_CYC_EN = 31;

    typedef enum logic [PMC_ADDR_W-1:0] {
        A_CTRL   = 4'd0,
        A_ENSET  = 4'd1,
        A_ENCLR  = 4'd2,
        A_SEL    = 4'd3,
        A_EVTYPE = 4'd4,
        A_EVCNT  = 4'd5,
        A_CYCLO  = 4'd6,
        A_CYCHI  = 4'd7,
        A_UACC   = 4'd8
    } pmc_addr_e;

    typedef struct packed {
        logic                  wr;
        logic                  priv;
        logic [PMC_ADDR_W-1:0] addr;
        logic [PMC_BUS_W-1:0]  data;
    } pmc_req_t;

    // uacc: [0] general, [2] cycle read, [3] event-count read
    function automatic logic pmc_access_ok(input pmc_req_t r, input logic [3:0] uacc);
        if (r.priv) return 1'b1;
        case (r.addr)
            A_UACC:          return !r.wr && uacc[0];
            A_EVCNT:         return r.wr ? uacc[0] : uacc[3];
            A_CYCLO, A_CYCHI: return r.wr ? uacc[0] : uacc[2];
            default:         return uacc[0];
        endcase
    endfunction

endpackage

// File: rtl/pmc_cycle_counter.sv
module pmc_cycle_counter #(
    parameter int CYC_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    output logic [CYC_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst || clear)
            value <= '0;
        else if (run)
            value <= value + 1'b1;
    end

    AST_CYC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> value == '0); // R5
    AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && !clear) |=> value == $past(value) + 1'b1); // R2
    AST_CYC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(value)); // R2

endmodule

// File: rtl/pmc_event_counter.sv
module pmc_event_counter #(
    parameter int CNT_W      = 32,
    parameter int EVT_W      = 8,
    parameter int NUM_EVT_IN = 10
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  count_en,
    input  logic [EVT_W-1:0]      evt_sel,
    input  logic [NUM_EVT_IN-1:0] events,
    input  logic                  clear,
    input  logic                  load,
    input  logic [CNT_W-1:0]      load_val,
    output logic [CNT_W-1:0]      value
);

    logic hit;

    // Only event numbers that name a real input can ever hit.
    always_comb begin
        hit = 1'b0;
        for (int j = 0; j < NUM_EVT_IN; j++)
            if (evt_sel == EVT_W'(j)) hit = events[j];
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            value <= '0;
        else if (load)
            value <= load_val;
        else if (count_en && hit)
            value <= value + 1'b1;
    end

    AST_EVT_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clear |=> value == '0); // R5
    AST_EVT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clear && !load && !count_en) |=> $stable(value)); // R3
    AST_EVT_BAD_NUM: assert property (@(posedge clk) disable iff (rst)
        (!clear && !load && evt_sel >= EVT_W'(NUM_EVT_IN)) |=> $stable(value)); // R8

endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
    import pmc_pkg::*;
#(
    parameter int NUM_CTR    = 6,
    parameter int NUM_EVT_IN = 10,
    parameter int EVT_W      = 8,
    parameter int CNT_W      = 32,
    parameter int CYC_W      = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_EVT_IN-1:0] evt_in,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_priv,
    input  logic [3:0]            req_addr,
    input  logic [31:0]           req_wdata,
    output logic                  rsp_valid,
    output logic [31:0]           rsp_data,
    output logic                  rsp_err
);

    localparam logic [31:0] EN_IMPL = {1'b1, 31'((32'd1 << NUM_CTR) - 32'd1)};
    localparam logic [3:0]  UACC_IMPL = 4'b1101;

    pmc_req_t          req;
    logic              allowed, do_wr, clr_cyc, clr_evt;
    logic              ctrl_en;
    logic [31:0]       en_q;
    logic [PMC_SEL_W-1:0] sel_q;
    logic [3:0]        uacc_q;
    logic [EVT_W-1:0]  evtype_q [NUM_CTR];
    logic [CNT_W-1:0]  cnt_val  [NUM_CTR];
    logic [CYC_W-1:0]  cyc_val;
    logic [EVT_W-1:0]  type_rd;
    logic [CNT_W-1:0]  cnt_rd;
    logic [31:0]       rd_val;

    assign req     = '{wr: req_write, priv: req_priv, addr: req_addr, data: req_wdata};
    assign allowed = pmc_access_ok(req, uacc_q);
    assign do_wr   = req_valid && req.wr && allowed;
    assign clr_cyc = do_wr && (req.addr == A_CTRL) && req.data[1];
    assign clr_evt = do_wr && (req.addr == A_CTRL) && req.data[2];

    // Indirect window: out-of-range select matches no counter and reads zero.
    always_comb begin
        type_rd = '0;
        cnt_rd  = '0;
        for (int i = 0; i < NUM_CTR; i++)
            if (sel_q == PMC_SEL_W'(i)) begin
                type_rd = evtype_q[i];
                cnt_rd  = cnt_val[i];
            end
    end

    always_comb begin
        case (req.addr)
            A_CTRL:          rd_val = {31'd0, ctrl_en};
            A_ENSET, A_ENCLR: rd_val = en_q;
            A_SEL:           rd_val = 32'(sel_q);
            A_EVTYPE:        rd_val = 32'(type_rd);
            A_EVCNT:         rd_val = 32'(cnt_rd);
            A_CYCLO:         rd_val = cyc_val[31:0];
            A_CYCHI:         rd_val = 32'(cyc_val >> 32);
            A_UACC:          rd_val = 32'(uacc_q);
            default:         rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_en   <= 1'b0;
            en_q      <= '0;
            sel_q     <= '0;
            uacc_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
            for (int i = 0; i < NUM_CTR; i++) evtype_q[i] <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !allowed;
            rsp_data  <= (req_valid && !req.wr && allowed) ? rd_val : '0;
            if (do_wr) begin
                case (req.addr)
                    A_CTRL:  ctrl_en <= req.data[0];
                    A_ENSET: en_q    <= en_q | (req.data & EN_IMPL);
                    A_ENCLR: en_q    <= en_q & ~req.data;
                    A_SEL:   sel_q   <= req.data[PMC_SEL_W-1:0];
                    A_UACC:  uacc_q  <= req.data[3:0] & UACC_IMPL;
                    A_EVTYPE:
                        for (int i = 0; i < NUM_CTR; i++)
                            if (sel_q == PMC_SEL_W'(i)) evtype_q[i] <= req.data[EVT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    pmc_cycle_counter #(.CYC_W(CYC_W)) u_cyc (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl_en && en_q[PMC_CYC_EN]),
        .clear (clr_cyc),
        .value (cyc_val)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_evt
        pmc_event_counter #(
            .CNT_W(CNT_W), .EVT_W(EVT_W), .NUM_EVT_IN(NUM_EVT_IN)
        ) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .count_en (ctrl_en && en_q[g]),
            .evt_sel  (evtype_q[g]),
            .events   (evt_in),
            .clear    (clr_evt),
            .load     (do_wr && req.addr == A_EVCNT && sel_q == PMC_SEL_W'(g)),
            .load_val (CNT_W'(req.data)),
            .value    (cnt_val[g])
        );
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R11
    AST_RSP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R11
    AST_DENY_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && rsp_data == '0)); // R9
    AST_DENY_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !allowed) |=> ($stable(en_q) && $stable(uacc_q) && $stable(sel_q))); // R9
    AST_UACC_NO_USER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !req_priv && req_addr == A_UACC) |=> rsp_err); // R9

endmodule

// File: tb/perf_counter_unit_test.sv
module perf_counter_unit_test;

    localparam int NEV = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NEV-1:0]  evt_in = '0;
    logic            req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
    logic [3:0]      req_addr = '0;
    logic [31:0]     req_wdata = '0;
    logic            rsp_valid, rsp_err;
    logic [31:0]     rsp_data;

    int checks = 0;
    int failures = 0;

    typedef struct { logic [31:0] data; logic err; string tag; } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    perf_counter_unit uut (
        .clk(clk), .rst(rst), .evt_in(evt_in),
        .req_valid(req_valid), .req_write(req_write), .req_priv(req_priv),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    // Monitor: pops one expected item per response.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL R11 unexpected response actual=%h expected=none", rsp_data);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (rsp_data !== e.data || rsp_err !== e.err) begin
                    failures++;
                    $display("FAIL %s actual=%h/err%0b expected=%h/err%0b",
                             e.tag, rsp_data, rsp_err, e.data, e.err);
                end
            end
        end
    end

    task automatic do_req(input logic wr, input logic pv, input logic [3:0] a,
                          input logic [31:0] wd, input logic [31:0] ed,
                          input logic ee, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_priv = pv; req_addr = a; req_wdata = wd;
        e.data = ed; e.err = ee; e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wr_p(input logic [3:0] a, input logic [31:0] d, input string tag);
        do_req(1'b1, 1'b1, a, d, 32'd0, 1'b0, tag);
    endtask

    task automatic rd_p(input logic [3:0] a, input logic [31:0] ed, input string tag);
        do_req(1'b0, 1'b1, a, 32'd0, ed, 1'b0, tag);
    endtask

    task automatic pulse(input int idx, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            evt_in[idx] = 1'b1;
        end
        @(negedge clk);
        evt_in[idx] = 1'b0;
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        checks++;
        if (rsp_valid !== 1'b0 || rsp_err !== 1'b0) begin
            failures++;
            $display("FAIL R1 rsp actual=%0b%0b expected=00", rsp_valid, rsp_err);
        end
        // R1 reset values
        rd_p(4'd0, 32'd0, "R1 ctrl");
        rd_p(4'd1, 32'd0, "R1 enable");
        rd_p(4'd3, 32'd0, "R1 select");
        rd_p(4'd4, 32'd0, "R1 evtype");
        rd_p(4'd5, 32'd0, "R1 evcount");
        rd_p(4'd6, 32'd0, "R1 cycle");
        rd_p(4'd8, 32'd0, "R1 uacc");

        // R4 enable set/clear
        wr_p(4'd1, 32'h8000_0007, "R11 write");
        rd_p(4'd1, 32'h8000_0007, "R4 set read");
        rd_p(4'd2, 32'h8000_0007, "R4 clear-address read");
        wr_p(4'd1, 32'hFFFF_FFFF, "R11 write");
        rd_p(4'd1, 32'h8000_003F, "R4 implemented bits");
        wr_p(4'd2, 32'h0000_0030, "R11 write");
        rd_p(4'd2, 32'h8000_000F, "R4 clear bits");
        wr_p(4'd2, 32'hFFFF_FFFF, "R11 write");

        // R2 cycle counter: counts on edges P1..P10
        wr_p(4'd1, 32'h8000_0000, "R11 write");
        wr_p(4'd0, 32'd1, "R11 write");
        repeat (9) @(posedge clk);
        wr_p(4'd0, 32'd0, "R11 write");
        rd_p(4'd6, 32'd10, "R2 cycle count");
        rd_p(4'd7, 32'd0, "R2 cycle high");
        rd_p(4'd6, 32'd10, "R2 cycle hold");
        wr_p(4'd0, 32'd2, "R11 write");
        rd_p(4'd6, 32'd0, "R5 cycle clear");
        wr_p(4'd2, 32'h8000_0000, "R11 write");

        // R3 / R6 event counting through the window
        wr_p(4'd3, 32'd0, "R11 write"); wr_p(4'd4, 32'd3, "R11 write");
        wr_p(4'd3, 32'd1, "R11 write"); wr_p(4'd4, 32'd5, "R11 write");
        wr_p(4'd3, 32'd2, "R11 write"); wr_p(4'd4, 32'd3, "R11 write");
        wr_p(4'd1, 32'h0000_0003, "R11 write");
        wr_p(4'd0, 32'd1, "R11 write");
        pulse(3, 4);
        pulse(5, 2);
        wr_p(4'd0, 32'd0, "R11 write");
        wr_p(4'd3, 32'd0, "R11 write");
        rd_p(4'd5, 32'd4, "R3 counter0 type3");
        wr_p(4'd3, 32'd1, "R11 write");
        rd_p(4'd5, 32'd2, "R3 counter1 type5");
        rd_p(4'd4, 32'd5, "R6 type readback");
        wr_p(4'd3, 32'd2, "R11 write");
        rd_p(4'd5, 32'd0, "R3 disabled counter2");
        rd_p(4'd6, 32'd0, "R2 cycle disabled bit31");

        // R3 global enable off
        pulse(3, 3);
        wr_p(4'd3, 32'd0, "R11 write");
        rd_p(4'd5, 32'd4, "R3 global off hold");

        // R6 load through window
        wr_p(4'd5, 32'd100, "R11 write");
        rd_p(4'd5, 32'd100, "R6 load");

        // R5 clear wins over same-cycle event
        wr_p(4'd0, 32'd1, "R11 write");
        begin
            exp_t e;
            @(negedge clk);
            evt_in[3] = 1'b1;
            req_valid = 1'b1; req_write = 1'b1; req_priv = 1'b1;
            req_addr = 4'd0; req_wdata = 32'd5;
            e.data = 32'd0; e.err = 1'b0; e.tag = "R11 write";
            sb_q.push_back(e);
            @(negedge clk);
            req_valid = 1'b0;
            evt_in[3] = 1'b0;
        end
        rd_p(4'd0, 32'd1, "R5 action bits read 0");
        wr_p(4'd0, 32'd0, "R11 write");
        rd_p(4'd5, 32'd0, "R5 clear beats event");

        // R7 out-of-range select
        wr_p(4'd3, 32'd6, "R11 write");
        rd_p(4'd4, 32'd0, "R7 type window zero");
        wr_p(4'd5, 32'd55, "R11 write");
        wr_p(4'd4, 32'd9, "R11 write");
        rd_p(4'd5, 32'd0, "R7 count window zero");
        wr_p(4'd3, 32'd31, "R11 write");
        rd_p(4'd4, 32'd0, "R7 select 31");
        wr_p(4'd3, 32'd0, "R11 write");
        rd_p(4'd5, 32'd0, "R7 counter0 untouched");
        rd_p(4'd4, 32'd3, "R7 type0 untouched");

        // R8 unbacked event number; counter1 still counts
        wr_p(4'd4, 32'd200, "R11 write");
        wr_p(4'd0, 32'd1, "R11 write");
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            evt_in = '1;
        end
        @(negedge clk);
        evt_in = '0;
        wr_p(4'd0, 32'd0, "R11 write");
        rd_p(4'd5, 32'd0, "R8 number 200 never counts");
        wr_p(4'd3, 32'd1, "R11 write");
        rd_p(4'd5, 32'd5, "R3 all-ones pattern");

        // R9 / R10 access control
        wr_p(4'd8, 32'h0000_0007, "R11 write");
        rd_p(4'd8, 32'h0000_0005, "R9 bit1 reads 0");
        wr_p(4'd0, 32'd1, "R11 write");
        do_req(1'b0, 1'b0, 4'd0, 32'd0, 32'd1, 1'b0, "R9 user ctrl read");
        do_req(1'b0, 1'b0, 4'd5, 32'd0, 32'd0, 1'b1, "R10 count read denied while enabled");
        do_req(1'b0, 1'b0, 4'd6, 32'd0, 32'd0, 1'b0, "R10 cycle read allowed");
        do_req(1'b1, 1'b0, 4'd8, 32'hF, 32'd0, 1'b1, "R9 user write uacc denied");
        rd_p(4'd8, 32'h0000_0005, "R9 uacc unchanged");
        wr_p(4'd0, 32'd0, "R11 write");
        wr_p(4'd8, 32'h0000_000D, "R11 write");
        do_req(1'b0, 1'b0, 4'd5, 32'd0, 32'd5, 1'b0, "R10 count read granted");
        wr_p(4'd8, 32'h0000_0004, "R11 write");
        do_req(1'b0, 1'b0, 4'd6, 32'd0, 32'd0, 1'b0, "R10 cycle read with bit2 only");
        do_req(1'b0, 1'b0, 4'd1, 32'd0, 32'd0, 1'b1, "R9 general denied");
        do_req(1'b1, 1'b0, 4'd2, 32'h3, 32'd0, 1'b1, "R9 user clear denied");
        rd_p(4'd1, 32'h0000_0003, "R9 enables unchanged");

        @(negedge clk);
        @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R11 missing responses actual=%0d expected=0", sb_q.size());
        end
        finish_run();
    end

endmodule